// File: doc/BRIEF.md
# Frame line address generator

This block walks a frame buffer held in system memory and emits, for every line of the frame, a request that carries the 48-bit byte address where the line starts and the number of bytes it spans. It serves one video pipeline. The frame can be stored as a single packed plane or split across two planes: luma plus interleaved chroma, or 16-bit colour plus an 8-bit alpha map. Each plane has its own base address and its own signed row increment. The increment is added after every line, so the block can read a rectangle out of a wider surface, skip lines, or walk the buffer bottom-up.

Software sets the configuration inputs and pulses `start`. The block checks the configuration, captures it, and selects one of two base-address sets. Set 0 serves the even field and set 1 the odd field. For each plane, 16 extension bits are placed above the 32-bit base. Requests leave on a valid/ready handshake. When a line needs both planes, the luma request goes first. A one-cycle `done` pulse closes the frame. A configuration that cannot be fetched raises `err`, and no request is issued.

Top module: `fbline_agen`

## Requirements
- R1: After reset, `req_valid`, `busy`, `done` and `err` are all low.
- R2: Format codes and bytes per pixel of the first plane are: 0 = 4-byte packed, 1 = 2-byte packed, 2 = packed YUV 4:2:2 (2 bytes per pixel), 3 = 1-byte packed, 4 = two-plane 4:2:0, 5 = two-plane 4:2:2 (both 1 byte luma), 6 = 2-byte colour plus alpha. Request n of the first plane has `req_plane`=0, `req_len` = width × bytes per pixel, and address = base + n × (`req_len` + row increment).
- R3: The row increment is a two's complement value. A positive increment skips bytes or whole lines. A negative increment moves the line start backwards.
- R4: The address is {extension, base}. Line stepping is done on all 48 bits, so a carry out of the low 32 bits reaches the extension bits.
- R5: With `cfg_field`=0 both planes start from set 0 (`*_0` inputs). With `cfg_field`=1 both start from set 1.
- R6: In formats 4, 5 and 6, a second-plane request (`req_plane`=1, `req_len` = width bytes) follows the first-plane request of the same line. Its address is chroma base + k × (width + chroma row increment), where k counts second-plane lines.
- R7: In format 4, the second plane is requested only after first-plane lines 0, 2, 4, and so on. This gives ceil(height/2) second-plane lines.
- R8: While `req_valid` is high and `req_ready` is low, `req_valid`, `req_addr`, `req_len` and `req_plane` hold their values.
- R9: `done` is high for exactly one cycle, the cycle after the last request of the frame is accepted. At that point `busy` and `req_valid` are low.
- R10: A start is refused, `err` is set and no request is issued if any of these hold: a base is not a multiple of its plane's pixel size (the second plane's pixel size is 2 bytes in formats 4 and 5 and 1 byte in format 6); the width is odd in formats 2, 4 or 5; the width or height is zero; or the format is 7. `err` is cleared by the next accepted start.
- R11: A start pulse while `busy` is high is ignored, and the frame in progress continues with its captured configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (single-cycle pulse) |
| cfg_fmt | input | 3 | Format code |
| cfg_field | input | 1 | Field selector: 0 even / set 0, 1 odd / set 1 |
| cfg_ba_y0 | input | 32 | First-plane base, set 0 |
| cfg_ba_y1 | input | 32 | First-plane base, set 1 |
| cfg_ext_y0 | input | 16 | First-plane extension bits, set 0 |
| cfg_ext_y1 | input | 16 | First-plane extension bits, set 1 |
| cfg_ba_c0 | input | 32 | Second-plane base, set 0 |
| cfg_ba_c1 | input | 32 | Second-plane base, set 1 |
| cfg_ext_c0 | input | 16 | Second-plane extension bits, set 0 |
| cfg_ext_c1 | input | 16 | Second-plane extension bits, set 1 |
| cfg_width | input | 13 | Line width in pixels |
| cfg_height | input | 12 | First-plane line count |
| cfg_rowinc_y | input | 32 | Signed first-plane row increment (bytes) |
| cfg_rowinc_c | input | 32 | Signed second-plane row increment (bytes) |
| req_ready | input | 1 | Consumer accepts the current request |
| req_valid | output | 1 | Line request present |
| req_plane | output | 1 | 0 first plane, 1 second plane |
| req_addr | output | 48 | Line start byte address |
| req_len | output | 15 | Line length in bytes |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame-complete pulse |
| err | output | 1 | Last start refused |

## Verification
Two kinds of event can fall in the same cycle. The first is a new start pulse arriving while a frame's requests are still being accepted. The second is the acceptance of the first-plane request together with the hand-over to the second plane of that line. The bench fires a start, with a changed base, in the middle of a stalled frame. It then checks that every later address still follows the captured base and that the frame ends normally. The bench also throttles `req_ready` to one cycle in three on two-plane frames, so the plane hand-over happens both with and without stalls. Every sampled request is compared against addresses computed from the closed-form line formula.

// File: rtl/fbline_pkg.sv
package fbline_pkg;

  typedef enum logic [2:0] {
    FMT_RGB32   = 3'd0,
    FMT_RGB16   = 3'd1,
    FMT_YUYV    = 3'd2,
    FMT_MONO8   = 3'd3,
    FMT_SP420   = 3'd4,
    FMT_SP422   = 3'd5,
    FMT_RGB_ALF = 3'd6,
    FMT_BAD     = 3'd7
  } fmt_e;

  // bytes per pixel of the first plane
  function automatic logic [2:0] p0_bytes(fmt_e f);
    case (f)
      FMT_RGB32:                      return 3'd4;
      FMT_RGB16, FMT_YUYV, FMT_RGB_ALF: return 3'd2;
      FMT_MONO8, FMT_SP420, FMT_SP422: return 3'd1;
      default:                        return 3'd0;
    endcase
  endfunction

  // alignment unit of the second plane
  function automatic logic [2:0] p1_bytes(fmt_e f);
    case (f)
      FMT_SP420, FMT_SP422: return 3'd2;
      FMT_RGB_ALF:          return 3'd1;
      default:              return 3'd0;
    endcase
  endfunction

  function automatic logic two_plane(fmt_e f);
    return (f == FMT_SP420) || (f == FMT_SP422) || (f == FMT_RGB_ALF);
  endfunction

  function automatic logic half_rate(fmt_e f);
    return f == FMT_SP420;
  endfunction

  function automatic logic needs_even_width(fmt_e f);
    return (f == FMT_YUYV) || (f == FMT_SP420) || (f == FMT_SP422);
  endfunction

  function automatic logic aligned(logic [1:0] low_bits, logic [2:0] unit);
    case (unit)
      3'd4:    return low_bits == 2'b00;
      3'd2:    return low_bits[0] == 1'b0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fbline_cfg_chk.sv
module fbline_cfg_chk
  import fbline_pkg::*;
#(
  parameter int WID_W = 13,
  parameter int HGT_W = 12
) (
  input  fmt_e             fmt,
  input  logic [1:0]       base_y_lo,
  input  logic [1:0]       base_c_lo,
  input  logic [WID_W-1:0] width,
  input  logic [HGT_W-1:0] height,
  output logic             cfg_bad
);
  logic bad_fmt, bad_size, bad_parity, bad_align_y, bad_align_c;

  assign bad_fmt     = (fmt == FMT_BAD);
  assign bad_size    = (width == '0) || (height == '0);
  assign bad_parity  = needs_even_width(fmt) && width[0];
  assign bad_align_y = !aligned(base_y_lo, p0_bytes(fmt));
  assign bad_align_c = two_plane(fmt) && !aligned(base_c_lo, p1_bytes(fmt));
  assign cfg_bad     = bad_fmt | bad_size | bad_parity | bad_align_y | bad_align_c;
endmodule

// File: rtl/fbline_plane_ptr.sv
module fbline_plane_ptr #(
  parameter int AW    = 48,
  parameter int LEN_W = 15,
  parameter int INC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    load_addr,
  input  logic             step,
  input  logic [LEN_W-1:0] len,
  input  logic [INC_W-1:0] inc,
  output logic [AW-1:0]    addr
);
  logic [AW-1:0] stride;

  // line length plus sign-extended row increment, full address width
  assign stride = AW'(len) + AW'($signed(inc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= addr + stride;
  end
endmodule

// File: rtl/fbline_seq.sv
module fbline_seq #(
  parameter int HGT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             two_pl,
  input  logic             half,
  input  logic [HGT_W-1:0] height,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_plane,
  output logic             y_step,
  output logic             c_step,
  output logic             line_adv,
  output logic             busy,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_LUMA, S_CHROMA} st_e;
  st_e              st;
  logic [HGT_W-1:0] line_q;
  logic             accept, need_c, last_line;

  assign req_valid = (st != S_IDLE);
  assign busy      = req_valid;
  assign req_plane = (st == S_CHROMA);
  assign accept    = req_valid && req_ready;
  assign y_step    = accept && (st == S_LUMA);
  assign c_step    = accept && (st == S_CHROMA);
  assign need_c    = two_pl && (!half || !line_q[0]);
  assign last_line = (line_q == height - 1'b1);
  assign line_adv  = (y_step && !need_c) || c_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      line_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (go) begin
          st     <= S_LUMA;
          line_q <= '0;
        end
      end else if (y_step && need_c) begin
        st <= S_CHROMA;
      end else if (line_adv) begin
        if (last_line) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else begin
          st     <= S_LUMA;
          line_q <= line_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fbline_agen.sv
module fbline_agen
  import fbline_pkg::*;
#(
  parameter int BA_W  = 32,
  parameter int EXT_W = 16,
  parameter int WID_W = 13,
  parameter int HGT_W = 12,
  parameter int INC_W = 32,
  localparam int AW    = BA_W + EXT_W,
  localparam int LEN_W = WID_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       cfg_fmt,
  input  logic             cfg_field,
  input  logic [BA_W-1:0]  cfg_ba_y0,
  input  logic [BA_W-1:0]  cfg_ba_y1,
  input  logic [EXT_W-1:0] cfg_ext_y0,
  input  logic [EXT_W-1:0] cfg_ext_y1,
  input  logic [BA_W-1:0]  cfg_ba_c0,
  input  logic [BA_W-1:0]  cfg_ba_c1,
  input  logic [EXT_W-1:0] cfg_ext_c0,
  input  logic [EXT_W-1:0] cfg_ext_c1,
  input  logic [WID_W-1:0] cfg_width,
  input  logic [HGT_W-1:0] cfg_height,
  input  logic [INC_W-1:0] cfg_rowinc_y,
  input  logic [INC_W-1:0] cfg_rowinc_c,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             req_plane,
  output logic [AW-1:0]    req_addr,
  output logic [LEN_W-1:0] req_len,
  output logic             busy,
  output logic             done,
  output logic             err
);
  fmt_e             fmt_in, fmt_q;
  logic [WID_W-1:0] width_q;
  logic [HGT_W-1:0] height_q;
  logic [INC_W-1:0] inc_q     [2];
  logic [AW-1:0]    load_addr [2];
  logic [AW-1:0]    ptr_addr  [2];
  logic [LEN_W-1:0] plane_len [2];
  logic             step      [2];
  logic             cfg_bad, start_take, go, y_step, c_step, line_adv;

  assign fmt_in       = fmt_e'(cfg_fmt);
  assign load_addr[0] = cfg_field ? {cfg_ext_y1, cfg_ba_y1} : {cfg_ext_y0, cfg_ba_y0};
  assign load_addr[1] = cfg_field ? {cfg_ext_c1, cfg_ba_c1} : {cfg_ext_c0, cfg_ba_c0};

  fbline_cfg_chk #(.WID_W(WID_W), .HGT_W(HGT_W)) u_chk (
    .fmt       (fmt_in),
    .base_y_lo (load_addr[0][1:0]),
    .base_c_lo (load_addr[1][1:0]),
    .width     (cfg_width),
    .height    (cfg_height),
    .cfg_bad   (cfg_bad)
  );

  assign start_take = start && !busy;
  assign go         = start_take && !cfg_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q    <= FMT_RGB32;
      width_q  <= '0;
      height_q <= '0;
      inc_q[0] <= '0;
      inc_q[1] <= '0;
      err      <= 1'b0;
    end else if (start_take) begin
      err <= cfg_bad;
      if (!cfg_bad) begin
        fmt_q    <= fmt_in;
        width_q  <= cfg_width;
        height_q <= cfg_height;
        inc_q[0] <= cfg_rowinc_y;
        inc_q[1] <= cfg_rowinc_c;
      end
    end
  end

  assign plane_len[0] = LEN_W'(width_q) * LEN_W'(p0_bytes(fmt_q));
  assign plane_len[1] = LEN_W'(width_q);
  assign step[0]      = y_step;
  assign step[1]      = c_step;

  for (genvar g = 0; g < 2; g++) begin : g_plane
    fbline_plane_ptr #(.AW(AW), .LEN_W(LEN_W), .INC_W(INC_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (go),
      .load_addr (load_addr[g]),
      .step      (step[g]),
      .len       (plane_len[g]),
      .inc       (inc_q[g]),
      .addr      (ptr_addr[g])
    );
  end

  fbline_seq #(.HGT_W(HGT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .two_pl    (two_plane(fmt_q)),
    .half      (half_rate(fmt_q)),
    .height    (height_q),
    .req_ready (req_ready),
    .req_valid (req_valid),
    .req_plane (req_plane),
    .y_step    (y_step),
    .c_step    (c_step),
    .line_adv  (line_adv),
    .busy      (busy),
    .done      (done)
  );

  assign req_addr = req_plane ? ptr_addr[1] : ptr_addr[0];
  assign req_len  = req_plane ? plane_len[1] : plane_len[0];
endmodule

// File: rtl/fbline_agen_chk.sv
module fbline_agen_chk #(
  parameter int AW    = 48,
  parameter int LEN_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             cfg_bad,
  input logic             line_adv,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_plane,
  input logic [AW-1:0]    req_addr,
  input logic [LEN_W-1:0] req_len,
  input logic             done,
  input logic             err
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_plane));

  assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready && line_adv) && !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_refuse_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && cfg_bad |=> !busy && err);

  assert_luma_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_plane |-> $past(req_valid) && $past(req_plane != req_ready));

  assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_len != '0);

  assert_ignore_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !(req_valid && req_ready) |=> busy);
endmodule

bind fbline_agen fbline_agen_chk #(.AW(AW), .LEN_W(LEN_W)) u_agen_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .cfg_bad   (cfg_bad),
  .line_adv  (line_adv),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_plane (req_plane),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .done      (done),
  .err       (err)
);

// File: tb/sim_fbline_agen.sv
module sim_fbline_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cfg_fmt = 3'd0;
  logic        cfg_field = 1'b0;
  logic [31:0] cfg_ba_y0 = 32'h8000_0000, cfg_ba_y1 = 32'h9000_0000;
  logic [15:0] cfg_ext_y0 = 16'h0001, cfg_ext_y1 = 16'h0002;
  logic [31:0] cfg_ba_c0 = 32'hA000_0000, cfg_ba_c1 = 32'hB000_0000;
  logic [15:0] cfg_ext_c0 = 16'h0003, cfg_ext_c1 = 16'h0004;
  logic [12:0] cfg_width = 13'd4;
  logic [11:0] cfg_height = 12'd2;
  logic [31:0] cfg_rowinc_y = '0, cfg_rowinc_c = '0;
  logic        req_ready = 1'b0;
  logic        req_valid, req_plane, busy, done, err;
  logic [47:0] req_addr;
  logic [14:0] req_len;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  localparam longint MASK48 = 64'h0000_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  fbline_agen u0 (.*);

  task automatic chk(input string tag, input bit ok, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int bpp0(input int f);
    case (f)
      0: return 4;
      1, 2, 6: return 2;
      default: return 1;
    endcase
  endfunction

  // one frame: compare every sampled request with the closed-form line formula
  task automatic run_frame(input string tag, input int f, input bit fld, input int w,
                           input int h, input int ry, input int rc,
                           input bit stall, input bit poke);
    longint by, bc, exp_a;
    int line = 0, pc = 0, cyc = 0, exp_l, cl;
    bit two, half, rdy;
    cfg_fmt = 3'(f); cfg_field = fld; cfg_width = 13'(w); cfg_height = 12'(h);
    cfg_rowinc_y = ry; cfg_rowinc_c = rc;
    by = fld ? longint'({cfg_ext_y1, cfg_ba_y1}) : longint'({cfg_ext_y0, cfg_ba_y0});
    bc = fld ? longint'({cfg_ext_c1, cfg_ba_c1}) : longint'({cfg_ext_c0, cfg_ba_c0});
    two = (f >= 4 && f <= 6);
    half = (f == 4);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (line < h && cyc < 2000) begin
      if (pc == 0) begin
        exp_l = w * bpp0(f);
        exp_a = (by + longint'(line) * longint'(exp_l + ry)) & MASK48;
      end else begin
        cl = half ? line / 2 : line;
        exp_l = w;
        exp_a = (bc + longint'(cl) * longint'(w + rc)) & MASK48;
      end
      chk(tag, req_valid === 1'b1 && req_plane === pc[0], "valid/plane",
          longint'({req_valid, req_plane}), longint'({1'b1, pc[0]}));
      chk(tag, longint'(req_addr) == exp_a, "addr", longint'(req_addr), exp_a);
      chk(tag, int'(req_len) == exp_l, "len", longint'(req_len), longint'(exp_l));
      rdy = stall ? (cyc % 3 == 2) : 1'b1;
      if (poke && cyc == 1) begin
        start = 1'b1;               // R11: start while busy, with a moved base
        cfg_ba_y0 = cfg_ba_y0 + 32'h40;
      end
      req_ready = rdy;
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (rdy) begin
        if (pc == 0 && two && (!half || line % 2 == 0)) pc = 1;
        else begin pc = 0; line++; end
      end
    end
    req_ready = 1'b0;
    chk("R9", done === 1'b1 && busy === 1'b0 && req_valid === 1'b0, "done/busy/valid",
        longint'({done, busy, req_valid}), 64'b100);
    @(negedge clk);
    chk("R9", done === 1'b0, "done pulse width", longint'(done), 0);
  endtask

  task automatic bad_start(input string why, input int f, input int w, input int h,
                           input logic [31:0] by, input logic [31:0] bc);
    logic [31:0] sy = cfg_ba_y0, sc = cfg_ba_c0;
    cfg_fmt = 3'(f); cfg_field = 1'b0; cfg_width = 13'(w); cfg_height = 12'(h);
    cfg_ba_y0 = by; cfg_ba_c0 = bc;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10", err === 1'b1 && busy === 1'b0 && req_valid === 1'b0, why,
        longint'({err, busy, req_valid}), 64'b100);
    repeat (3) @(negedge clk);
    chk("R10", req_valid === 1'b0, {why, " stays idle"}, longint'(req_valid), 0);
    cfg_ba_y0 = sy; cfg_ba_c0 = sc;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", req_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && err === 1'b0,
        "reset outputs", longint'({req_valid, busy, done, err}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame("R2", 0, 0, 5, 3, 0, 0, 0, 0);
    run_frame("R3", 1, 0, 6, 4, 12, 0, 1, 0);          // skip every other line, stalled (R8)
    cfg_ba_y0 = 32'h0000_1000;
    run_frame("R3", 3, 0, 4, 3, -8, 0, 0, 0);          // bottom-up walk
    cfg_ba_y0 = 32'hFFFF_FFF0; cfg_ext_y0 = 16'h0012;
    run_frame("R4", 0, 0, 8, 3, 0, 0, 0, 0);           // carry into extension bits
    cfg_ba_y0 = 32'h8000_0000; cfg_ext_y0 = 16'h0001;
    run_frame("R5", 5, 1, 8, 3, 16, 8, 0, 0);          // odd field, set 1
    run_frame("R7", 4, 0, 10, 5, 0, 6, 1, 0);          // 4:2:0, stalled (R6, R8)
    run_frame("R6", 6, 0, 7, 2, 2, 1, 1, 0);           // colour plus alpha
    run_frame("R2", 2, 0, 6, 2, 0, 0, 0, 0);           // packed YUV 4:2:2
    bad_start("misaligned 4-byte base", 0, 4, 2, 32'h8000_0002, 32'hA000_0000);
    bad_start("odd width 4:2:2", 2, 5, 2, 32'h8000_0000, 32'hA000_0000);
    bad_start("reserved format", 7, 4, 2, 32'h8000_0000, 32'hA000_0000);
    bad_start("odd chroma base", 4, 4, 2, 32'h8000_0000, 32'hA000_0001);
    bad_start("zero height", 3, 4, 0, 32'h8000_0000, 32'hA000_0000);
    run_frame("R11", 0, 0, 4, 4, 0, 0, 1, 1);
    chk("R10", err === 1'b0, "err cleared by good start", longint'(err), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule